// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block runs the address phase of an I2C controller transaction, between the start condition and the first data byte. A caller pulses a request with a slave address, a 7-bit or 10-bit select, a read/write direction and a flag marking a message that continues the previous one without a new start. The sequencer works out the address bytes, passes them one at a time to a separate byte engine, and checks the acknowledge the engine returns for each byte.

For a 10-bit read the sequencer runs the whole sequence itself. It sends the header in write direction, then the low address byte, then asks the byte engine for a repeated start, then sends the header again with the read bit set. The sequence ends with a one-cycle done pulse. An error flag raised with it reports an address NAK, and the caller must then issue a stop. Data bytes, stop generation and bus bit timing belong to other blocks.

Top module: `i2c_addr_phase`

## Requirements
- R1: For a 7-bit address exactly one byte is sent, equal to {addr[6:0], rd}, where rd is 1 for a read and 0 for a write.
- R2: For a 10-bit address the first byte is {5'b11110, addr[9:8], 1'b0}, in both directions.
- R3: For a 10-bit address the second byte is addr[7:0]. A 10-bit write ends after it.
- R4: For a 10-bit read, after the second byte is acknowledged, exactly one restart request is issued. Once restart_done is seen, the third byte {5'b11110, addr[9:8], 1'b1} is sent. No other sequence issues a restart request.
- R5: A byte that completes with byte_nak=1 ends the sequence. done pulses with err=1 in the cycle after the completion, and no further byte or restart request follows.
- R6: A request with no_start=1 sends no byte and pulses done with err=0 in the cycle after the request.
- R7: When the last address byte is acknowledged, done pulses for one cycle with err=0 in the next cycle.
- R8: A request is accepted only while the sequencer is idle. A request that arrives during a sequence has no effect on the bytes sent or on the outcome, and starts no sequence afterwards.
- R9: byte_req is a one-cycle pulse. byte_data is valid with it and stays unchanged until the byte engine reports completion.
- R10: After reset byte_req, restart_req, done and err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start pulse; the inputs below are sampled with it |
| addr | input | 10 | Slave address; only bits 6:0 are used in 7-bit mode |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| rd | input | 1 | 1 for a read message, 0 for a write |
| no_start | input | 1 | 1 skips the address phase entirely |
| byte_req | output | 1 | One-cycle request to the byte engine to send byte_data |
| byte_data | output | 8 | Address byte to transmit |
| byte_done | input | 1 | Byte engine finished the requested byte |
| byte_nak | input | 1 | Qualifies byte_done: the byte was not acknowledged |
| restart_req | output | 1 | One-cycle request to the byte engine for a repeated start |
| restart_done | input | 1 | Byte engine finished the repeated start |
| done | output | 1 | One-cycle end-of-phase pulse |
| err | output | 1 | With done: address NAK, the caller should issue a stop |

## Verification
The assertions assume that the byte engine raises byte_done only after a byte_req, and raises restart_done only after a restart_req. They also assume that byte_nak is meaningful only together with byte_done. The bench's responder keeps to this: it answers each request once, two cycles later, and sets the NAK only on the byte index a vector selects. Requests that arrive while a sequence runs are injected deliberately, to show that the idle-only acceptance holds.

// File: rtl/i2c_addr_phase_pkg.sv
package i2c_addr_phase_pkg;

    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam logic [4:0] HDR_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT_B,
        S_RSTART,
        S_WAIT_R,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        K_ADDR7,
        K_HDR_W,
        K_LOW,
        K_HDR_R
    } byte_kind_e;

    typedef struct packed {
        seq_state_e        state;
        byte_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic              ten;
        logic              rd;
        logic              err;
    } seq_regs_t;

endpackage

// File: rtl/addr_byte_gen.sv
module addr_byte_gen
    import i2c_addr_phase_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  byte_kind_e      kind,
    input  logic [AW-1:0]   addr,
    input  logic            rd,
    output logic [BW-1:0]   data
);
    localparam int HI_LSB = BW;

    always_comb begin
        unique case (kind)
            K_ADDR7: data = {addr[BW-2:0], rd};
            K_HDR_W: data = {HDR_PREFIX, addr[AW-1:HI_LSB], 1'b0};
            K_LOW:   data = addr[BW-1:0];
            default: data = {HDR_PREFIX, addr[AW-1:HI_LSB], 1'b1};
        endcase
    end
endmodule

// File: rtl/addr_phase_fsm.sv
module addr_phase_fsm
    import i2c_addr_phase_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          ten_bit,
    input  logic          rd,
    input  logic          no_start,
    input  logic          byte_done,
    input  logic          byte_nak,
    input  logic          restart_done,
    output byte_kind_e    kind,
    output logic [AW-1:0] addr_q_o,
    output logic          rd_q_o,
    output logic          issuing,
    output logic          waiting_byte,
    output logic          byte_req,
    output logic          restart_req,
    output logic          done,
    output logic          err
);
    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            S_IDLE: begin
                r_d.err = 1'b0;
                if (req) begin
                    r_d.addr = addr;
                    r_d.ten  = ten_bit;
                    r_d.rd   = rd;
                    r_d.kind = ten_bit ? K_HDR_W : K_ADDR7;
                    r_d.state = no_start ? S_FIN : S_ISSUE;
                end
            end
            S_ISSUE: r_d.state = S_WAIT_B;
            S_WAIT_B: begin
                if (byte_done) begin
                    if (byte_nak) begin
                        r_d.err   = 1'b1;
                        r_d.state = S_FIN;
                    end else begin
                        unique case (r_q.kind)
                            K_HDR_W: begin
                                r_d.kind  = K_LOW;
                                r_d.state = S_ISSUE;
                            end
                            K_LOW: r_d.state = r_q.rd ? S_RSTART : S_FIN;
                            default: r_d.state = S_FIN;
                        endcase
                    end
                end
            end
            S_RSTART: r_d.state = S_WAIT_R;
            S_WAIT_R: begin
                if (restart_done) begin
                    r_d.kind  = K_HDR_R;
                    r_d.state = S_ISSUE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, kind: K_ADDR7, addr: '0, ten: 1'b0, rd: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign kind         = r_q.kind;
    assign addr_q_o     = r_q.addr;
    assign rd_q_o       = r_q.rd;
    assign issuing      = (r_q.state == S_ISSUE);
    assign waiting_byte = (r_q.state == S_WAIT_B);
    assign byte_req     = issuing;
    assign restart_req  = (r_q.state == S_RSTART);
    assign done         = (r_q.state == S_FIN);
    assign err          = done & r_q.err;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> !byte_req); // R9
    AST_NAK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_byte && byte_done && byte_nak) |=> (done && err)); // R5
    AST_RS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (r_q.ten && r_q.rd)); // R4
    AST_NOSTART_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE && req && no_start) |=> (done && !err && !byte_req)); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_req, restart_req, done})); // R5
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_byte && !byte_done && req) |=> ($stable(r_q.addr) && waiting_byte)); // R8
endmodule

// File: rtl/i2c_addr_phase.sv
module i2c_addr_phase
    import i2c_addr_phase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ten_bit,
    input  logic              rd,
    input  logic              no_start,
    output logic              byte_req,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_done,
    input  logic              byte_nak,
    output logic              restart_req,
    input  logic              restart_done,
    output logic              done,
    output logic              err
);
    byte_kind_e        kind;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic              issuing;
    logic              waiting_byte;

    addr_phase_fsm #(.AW(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .addr         (addr),
        .ten_bit      (ten_bit),
        .rd           (rd),
        .no_start     (no_start),
        .byte_done    (byte_done),
        .byte_nak     (byte_nak),
        .restart_done (restart_done),
        .kind         (kind),
        .addr_q_o     (addr_q),
        .rd_q_o       (rd_q),
        .issuing      (issuing),
        .waiting_byte (waiting_byte),
        .byte_req     (byte_req),
        .restart_req  (restart_req),
        .done         (done),
        .err          (err)
    );

    addr_byte_gen #(.AW(ADDR_W), .BW(BYTE_W)) u_gen (
        .kind (kind),
        .addr (addr_q),
        .rd   (rd_q),
        .data (byte_data)
    );

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_byte && $past(issuing)) |-> $stable(byte_data)); // R9
    AST_DATA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_byte && $past(waiting_byte)) |-> $stable(byte_data)); // R9
endmodule

// File: tb/i2c_addr_phase_tb.sv
module i2c_addr_phase_tb;

    typedef struct packed {
        logic [9:0] addr;
        logic       ten;
        logic       rd;
        logic       ns;
        logic [1:0] nak_at;
        logic [1:0] nb;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       rs;
        logic       er;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{10'h050, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 8'hA0, 8'h00, 8'h00, 1'b0, 1'b0},
        '{10'h050, 1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 8'hA1, 8'h00, 8'h00, 1'b0, 1'b0},
        '{10'h2A5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 8'hF4, 8'hA5, 8'h00, 1'b0, 1'b0},
        '{10'h2A5, 1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 8'hF4, 8'hA5, 8'hF5, 1'b1, 1'b0},
        '{10'h1FF, 1'b1, 1'b1, 1'b0, 2'd2, 2'd2, 8'hF2, 8'hFF, 8'h00, 1'b0, 1'b1},
        '{10'h07F, 1'b0, 1'b1, 1'b0, 2'd1, 2'd1, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1},
        '{10'h123, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        '{10'h3C3, 1'b1, 1'b1, 1'b0, 2'd3, 2'd3, 8'hF6, 8'hC3, 8'hF7, 1'b1, 1'b1},
        '{10'h000, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 8'hF0, 8'h00, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_drv = 1'b0;
    logic       inj_req = 1'b0;
    logic [9:0] addr = '0;
    logic       ten_bit = 1'b0, rd = 1'b0, no_start = 1'b0;
    logic       byte_req, restart_req, done, err;
    logic [7:0] byte_data;
    logic       byte_done = 1'b0, byte_nak = 1'b0, restart_done = 1'b0;

    int errors = 0;
    int checks = 0;
    logic finished = 1'b0;

    logic [7:0] got [4];
    int  nbytes = 0;
    int  nrs = 0;
    int  nak_at = 0;
    int  bcnt = 0;
    int  rcnt = 0;
    logic inject_en = 1'b0;
    logic hold_bad = 1'b0;
    logic [7:0] held;

    always #4 clk = ~clk;

    i2c_addr_phase u_dut (
        .clk (clk), .rst_n (rst_n), .req (req_drv | inj_req), .addr (addr),
        .ten_bit (ten_bit), .rd (rd), .no_start (no_start),
        .byte_req (byte_req), .byte_data (byte_data),
        .byte_done (byte_done), .byte_nak (byte_nak),
        .restart_req (restart_req), .restart_done (restart_done),
        .done (done), .err (err)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Byte engine model: answers each request two cycles later.
    always @(negedge clk) begin
        inj_req = 1'b0;
        byte_done = 1'b0;
        byte_nak = 1'b0;
        restart_done = 1'b0;
        if (bcnt > 0) begin
            if (byte_data !== held) hold_bad = 1'b1;
            bcnt--;
            if (bcnt == 0) begin
                byte_done = 1'b1;
                byte_nak = (nbytes == nak_at);
            end
        end
        if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) restart_done = 1'b1;
        end
        if (byte_req) begin
            if (nbytes < 4) got[nbytes] = byte_data;
            held = byte_data;
            nbytes++;
            bcnt = 2;
            if (inject_en) begin
                inj_req = 1'b1;
                addr = 10'h011;
                ten_bit = 1'b0;
                no_start = 1'b1;
            end
        end
        if (restart_req) begin
            nrs++;
            rcnt = 2;
        end
    end

    task automatic run_vec(input vec_t v, input string tag);
        logic seen_done = 1'b0;
        logic seen_err = 1'b0;
        int wd = 0;
        nbytes = 0; nrs = 0; nak_at = v.nak_at; hold_bad = 1'b0;
        @(negedge clk);
        addr = v.addr; ten_bit = v.ten; rd = v.rd; no_start = v.ns;
        req_drv = 1'b1;
        @(negedge clk);
        req_drv = 1'b0;
        while (!seen_done && wd < 200) begin
            if (done) begin
                seen_done = 1'b1;
                seen_err = err;
            end else begin
                @(negedge clk);
                wd++;
            end
        end
        repeat (6) @(negedge clk);
        chk(seen_done, {tag, " R7 done seen"}, seen_done, 1);
        chk(nbytes == v.nb, {tag, " R1/R5 byte count"}, nbytes, v.nb);
        if (v.nb >= 1) chk(got[0] == v.b0, {tag, (v.ten ? " R2 header" : " R1 7-bit byte")}, got[0], v.b0);
        if (v.nb >= 2) chk(got[1] == v.b1, {tag, " R3 low byte"}, got[1], v.b1);
        if (v.nb >= 3) chk(got[2] == v.b2, {tag, " R4 read header"}, got[2], v.b2);
        chk(nrs == v.rs, {tag, " R4 restart count"}, nrs, v.rs);
        chk(seen_err == v.er, {tag, (v.er ? " R5 nak err" : " R7 ok err")}, seen_err, v.er);
        if (v.ns) chk(nbytes == 0, {tag, " R6 no byte"}, nbytes, 0);
        chk(!hold_bad, {tag, " R9 byte_data held"}, hold_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({byte_req, restart_req, done, err} == 4'b0, "R10 outputs in reset",
            {byte_req, restart_req, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({byte_req, restart_req, done, err} == 4'b0, "R10 outputs after reset",
            {byte_req, restart_req, done, err}, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R8: request during a 10-bit read is ignored
        inject_en = 1'b1;
        run_vec(VECS[3], "R8 busy request");
        inject_en = 1'b0;
        chk(!done && !byte_req, "R8 no late sequence", {done, byte_req}, 0);

        // R9: byte_req lasts one cycle
        begin
            int hi = 0;
            nbytes = 0; nak_at = 0;
            @(negedge clk);
            addr = 10'h033; ten_bit = 1'b0; rd = 1'b0; no_start = 1'b0;
            req_drv = 1'b1;
            @(negedge clk);
            req_drv = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (byte_req) hi++;
                @(negedge clk);
            end
            chk(hi == 1, "R9 byte_req one cycle", hi, 1);
            repeat (6) @(negedge clk);
            chk(got[0] == 8'h66, "R1 7-bit write 0x33", got[0], 8'h66);
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule